// File: doc/BRIEF.md
# Fractional SCL Tick Divider

This block derives the phase tick of a two-wire serial bus controller from a 100 MHz module clock. Rather than counting down a whole number of cycles, it keeps a fractional phase accumulator: every counting cycle it adds a step value. Whenever the running total reaches a wrap modulus (a configured limit plus one), the modulus is subtracted and a one-cycle tick is issued. The SCL driver toggles its clock phase on each tick, so the tick rate is twice the SCL rate. Because the step is a fraction of the modulus, clock ratios that are not whole numbers can be produced. The average ratio is still exact.

Two setting registers are held. One is for the slow bus speeds (standard and fast) and one is for high speed. Each is loaded from a shared write bus that carries a step field and a limit field. A non-zero high-speed register takes priority. A non-zero slow register is used otherwise. When both are zero the block is idle. Counting only runs while the run enable is high. Dropping run enable, or writing either register, clears the accumulator so that the next count starts from a known phase.

Top module: `scl_frac_divider`

## Requirements
- R1: A setting word carries the limit in bits [DEC_W-1:0] and the step in bits [DEC_W+INC_W-1:DEC_W]. `slow_we` loads it into the slow register and `fast_we` loads it into the high-speed register. A non-zero word must have step <= limit+1.
- R2: Take E as the number of counting cycles since the accumulator was last cleared. After E cycles the number of ticks issued equals floor(E*step/(limit+1)). Each tick lasts one cycle and appears one clock after the edge on which the total wraps.
- R3: Step 1 with limit 499 ticks every 500 cycles, which gives 200 kHz for a 100 kHz bus. Step 1 with limit 124 ticks every 125 cycles, which gives 800 kHz for a 400 kHz bus.
- R4: A non-zero high-speed register (for example step 41, limit 152) sets the rate even when the slow register is also non-zero. When the high-speed register is written back to zero, the slow setting applies again.
- R5: When both registers are zero, no tick is produced.
- R6: While `run_en` is low, no tick is produced and the accumulator is zero. Counting restarts from zero after `run_en` rises.
- R7: A write to either register, even while running, clears the accumulator and gives no tick on that edge. Counting with the new setting begins on the next edge.
- R8: A step of 0 never ticks. A step of 1 with a limit of 0 ticks on every counting cycle.
- R9: Reset clears both registers and drives `tick` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Counting enable; low clears the accumulator |
| slow_we | input | 1 | Load `cfg_wdata` into the slow-speed register |
| fast_we | input | 1 | Load `cfg_wdata` into the high-speed register |
| cfg_wdata | input | INC_W+DEC_W | Setting word: step in the upper field, limit in the lower field |
| tick | output | 1 | One-cycle pulse at twice the SCL rate |

## Verification
The assertions rely on one property of the inputs: every non-zero setting has a step no larger than the limit plus one. Under that condition the accumulator stays below the modulus. The checker enforces this condition as an assertion on each write. The bench only ever writes zero or legal pairs. The small exhaustive sweep covers step values 0 to 4 and limits 0 to 9, and it skips any pair that breaks the condition. No write during the run depends on which register is active except through that same rule.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_SLOW = 2'd1,
    SRC_FAST = 2'd2
  } src_e;

  // True when adding the step to the running total reaches the modulus.
  function automatic logic step_wraps(input logic [31:0] acc,
                                      input logic [31:0] step,
                                      input logic [31:0] modv);
    return (acc + step) >= modv;
  endfunction

  // New accumulator value after one counting cycle.
  function automatic logic [31:0] step_next(input logic [31:0] acc,
                                            input logic [31:0] step,
                                            input logic [31:0] modv);
    logic [31:0] sum;
    sum = acc + step;
    return (sum >= modv) ? (sum - modv) : sum;
  endfunction

endpackage

// File: rtl/scl_div_cfg_regs.sv
module scl_div_cfg_regs
  import scl_div_pkg::*;
#(
  parameter int INC_W = 8,
  parameter int DEC_W = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   slow_we,
  input  logic                   fast_we,
  input  logic [INC_W+DEC_W-1:0] cfg_wdata,
  output src_e                   src,
  output logic [INC_W-1:0]       act_inc,
  output logic [DEC_W-1:0]       act_dec
);
  localparam int CFG_W = INC_W + DEC_W;

  logic [CFG_W-1:0] slow_q;
  logic [CFG_W-1:0] fast_q;
  logic [CFG_W-1:0] act_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q <= '0;
      fast_q <= '0;
    end else begin
      if (slow_we) slow_q <= cfg_wdata;
      if (fast_we) fast_q <= cfg_wdata;
    end
  end

  // High-speed register wins whenever it holds anything.
  always_comb begin
    if (fast_q != '0) begin
      src      = SRC_FAST;
      act_word = fast_q;
    end else if (slow_q != '0) begin
      src      = SRC_SLOW;
      act_word = slow_q;
    end else begin
      src      = SRC_IDLE;
      act_word = '0;
    end
  end

  assign act_dec = act_word[DEC_W-1:0];
  assign act_inc = act_word[CFG_W-1:DEC_W];

endmodule

// File: rtl/scl_div_accum.sv
module scl_div_accum
  import scl_div_pkg::*;
#(
  parameter int INC_W = 8,
  parameter int DEC_W = 10,
  parameter int ACC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  input  logic [DEC_W-1:0] dec,
  output logic             wrap,
  output logic [ACC_W-1:0] acc,
  output logic             tick
);
  logic [31:0]      modv;
  logic [ACC_W-1:0] acc_nxt;

  assign modv    = 32'(dec) + 32'd1;
  assign wrap    = en && step_wraps(32'(acc), 32'(inc), modv);
  assign acc_nxt = ACC_W'(step_next(32'(acc), 32'(inc), modv));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (clr) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (en) begin
      acc  <= acc_nxt;
      tick <= wrap;
    end else begin
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/scl_frac_divider.sv
module scl_frac_divider
  import scl_div_pkg::*;
#(
  parameter int INC_W = 8,
  parameter int DEC_W = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run_en,
  input  logic                   slow_we,
  input  logic                   fast_we,
  input  logic [INC_W+DEC_W-1:0] cfg_wdata,
  output logic                   tick
);
  localparam int ACC_W = ((DEC_W > INC_W) ? DEC_W : INC_W) + 2;

  src_e             src;
  logic [INC_W-1:0] act_inc;
  logic [DEC_W-1:0] act_dec;
  logic             cfg_wr;
  logic             acc_clr;
  logic             acc_en;
  logic             acc_wrap;
  logic [ACC_W-1:0] acc_val;

  assign cfg_wr  = slow_we || fast_we;
  assign acc_clr = !run_en || cfg_wr;
  assign acc_en  = (src != SRC_IDLE);

  scl_div_cfg_regs #(.INC_W(INC_W), .DEC_W(DEC_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_we   (slow_we),
    .fast_we   (fast_we),
    .cfg_wdata (cfg_wdata),
    .src       (src),
    .act_inc   (act_inc),
    .act_dec   (act_dec)
  );

  scl_div_accum #(.INC_W(INC_W), .DEC_W(DEC_W), .ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (acc_clr),
    .en    (acc_en),
    .inc   (act_inc),
    .dec   (act_dec),
    .wrap  (acc_wrap),
    .acc   (acc_val),
    .tick  (tick)
  );

endmodule

// File: rtl/scl_frac_divider_chk.sv
module scl_frac_divider_chk
  import scl_div_pkg::*;
#(
  parameter int INC_W = 8,
  parameter int DEC_W = 10,
  parameter int ACC_W = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   run_en,
  input logic                   slow_we,
  input logic                   fast_we,
  input logic [INC_W+DEC_W-1:0] cfg_wdata,
  input logic                   tick,
  input src_e                   src,
  input logic [DEC_W-1:0]       act_dec,
  input logic [ACC_W-1:0]       acc_val
);
  logic [31:0] w_inc;
  logic [31:0] w_dec;
  assign w_inc = 32'(cfg_wdata[INC_W+DEC_W-1:DEC_W]);
  assign w_dec = 32'(cfg_wdata[DEC_W-1:0]);

  AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ((slow_we || fast_we) && cfg_wdata != '0) |-> (w_inc <= w_dec + 32'd1)); // R1

  AST_ACC_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    32'(acc_val) <= 32'(act_dec)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_IDLE && !slow_we && !fast_we) |=> !tick); // R5

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!tick && acc_val == '0)); // R6

  AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_we || fast_we) |=> (!tick && acc_val == '0)); // R7

endmodule

bind scl_frac_divider scl_frac_divider_chk #(
  .INC_W(INC_W), .DEC_W(DEC_W), .ACC_W(ACC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_en    (run_en),
  .slow_we   (slow_we),
  .fast_we   (fast_we),
  .cfg_wdata (cfg_wdata),
  .tick      (tick),
  .src       (src),
  .act_dec   (act_dec),
  .acc_val   (acc_val)
);

// File: tb/scl_frac_divider_tb.sv
module scl_frac_divider_tb;
  localparam int INC_W = 8;
  localparam int DEC_W = 10;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   run_en = 1'b0;
  logic                   slow_we = 1'b0;
  logic                   fast_we = 1'b0;
  logic [INC_W+DEC_W-1:0] cfg_wdata = '0;
  logic                   tick;

  int    nvec = 0;
  int    nfail = 0;
  bit    done = 0;
  string cur_req = "R9";

  // Bench-side model of the setting registers and the counting state.
  longint m_slow_inc = 0, m_slow_dec = 0, m_fast_inc = 0, m_fast_dec = 0;
  longint e_cnt = 0;
  bit     exp_tick = 0;

  always #5 clk = ~clk;

  scl_frac_divider #(.INC_W(INC_W), .DEC_W(DEC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .slow_we(slow_we),
    .fast_we(fast_we), .cfg_wdata(cfg_wdata), .tick(tick)
  );

  task automatic model_edge();
    longint inc, dec, md;
    bit active;
    if (!rst_n) begin
      m_slow_inc = 0; m_slow_dec = 0; m_fast_inc = 0; m_fast_dec = 0;
      e_cnt = 0; exp_tick = 0;
      return;
    end
    if (!run_en || slow_we || fast_we) begin
      e_cnt = 0; exp_tick = 0;
    end else begin
      active = 1;
      if (m_fast_inc != 0 || m_fast_dec != 0) begin
        inc = m_fast_inc; dec = m_fast_dec;
      end else if (m_slow_inc != 0 || m_slow_dec != 0) begin
        inc = m_slow_inc; dec = m_slow_dec;
      end else begin
        active = 0; inc = 0; dec = 0;
      end
      if (active) begin
        md = dec + 1;
        e_cnt++;
        exp_tick = ((e_cnt * inc) / md) != (((e_cnt - 1) * inc) / md);
      end else begin
        exp_tick = 0;
      end
    end
    if (slow_we) begin
      m_slow_inc = longint'(cfg_wdata >> DEC_W);
      m_slow_dec = longint'(cfg_wdata[DEC_W-1:0]);
    end
    if (fast_we) begin
      m_fast_inc = longint'(cfg_wdata >> DEC_W);
      m_fast_dec = longint'(cfg_wdata[DEC_W-1:0]);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    #1;
    nvec++;
    if (tick !== exp_tick) begin
      nfail++;
      $display("FAIL %s: tick=%0b expected=%0b (count %0d)", cur_req, tick, exp_tick, e_cnt);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(input bit fast, input int inc, input int dec);
    cfg_wdata = {INC_W'(inc), DEC_W'(dec)};
    slow_we = !fast;
    fast_we = fast;
    cyc();
    slow_we = 1'b0;
    fast_we = 1'b0;
  endtask

  initial begin
    cur_req = "R9";
    run(4);
    rst_n = 1'b1;
    run(4);

    cur_req = "R5";
    run_en = 1'b1;
    run(200);

    cur_req = "R3";
    run_en = 1'b0;
    wr(0, 1, 499);
    run_en = 1'b1;
    run(1600);
    run_en = 1'b0;
    wr(0, 1, 124);
    run_en = 1'b1;
    run(600);

    cur_req = "R4";
    run_en = 1'b0;
    wr(1, 41, 152);
    run_en = 1'b1;
    run(800);

    cur_req = "R6";
    run_en = 1'b0;
    run(50);
    run_en = 1'b1;
    run(300);

    cur_req = "R7";
    run(37);
    wr(1, 3, 20);
    run(200);
    cur_req = "R4";
    wr(1, 0, 0);
    run(300);

    cur_req = "R2";
    run_en = 1'b0;
    run(2);
    for (int inc = 0; inc <= 4; inc++) begin
      for (int dec = 0; dec <= 9; dec++) begin
        if (inc <= dec + 1 && !(inc == 0 && dec == 0)) begin
          cur_req = (inc == 0 || dec == 0) ? "R8" : "R2";
          run_en = 1'b0;
          wr(0, inc, dec);
          run_en = 1'b1;
          run(40);
        end
      end
    end

    cur_req = "R1";
    run_en = 1'b0;
    wr(0, 0, 0);
    run_en = 1'b1;
    run(50);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule